// File: doc/BRIEF.md
# Timer Interrupt Route Selector

This block sits between a set of timer channels and the interrupt fabric. Each timer raises a one-cycle fire pulse when its comparator matches. The selector turns each fire into an interrupt event. In the normal case the event is a single-cycle edge on one of the I/O interrupt inputs, chosen by a 5-bit route field in that timer's 64-bit config word. Before delivery the route is checked against a capability bitmask that is also carried in the config word. A route that the mask does not allow produces no edge. Instead, a per-timer error flag is set and stays set.

A legacy replacement mode sends the first two timers to two fixed legacy lines, called line 0 and line 8, whatever their route fields say. The third timer keeps using its route field in this mode. A legacy delivery briefly drops the line and then raises it again, so a level-sensitive controller sees a fresh edge. While legacy mode is on and timer 0 is enabled, a mute output tells the companion legacy interval timer to hold back its own channel-0 interrupt.

Top module: `tmr_irq_route`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every output is zero.
- R2: A fire from timer n counts only when enable bit 2 of its config is set. If the route r in config bits 13:9 is below 24, config bit 32+r is set and timer n is not in legacy replacement, then `irq_edge_o[r]` is high for exactly the one cycle after the clock edge that samples the fire.
- R3: If the route is 24 or higher, or config bit 32+r is clear, a counted fire from a non-legacy timer raises no edge, and `route_err_o[n]` becomes 1 one clock edge after the fire is sampled.
- R4: Once set, a `route_err_o` bit stays 1 until reset, through any later traffic.
- R5: With `legacy_mode_i` high, timer 0 delivers to legacy index 0 (line 0) and timer 1 to legacy index 1 (line 8). Their route fields and capability bits are ignored: no `irq_edge_o` bit and no error result from them.
- R6: A legacy delivery drives `legacy_line_o[k]` low in the cycle after the fire is sampled. In the next cycle the line goes high with `legacy_pulse_o[k]` high for that one cycle. The line then stays high until the next delivery on that index.
- R7: In legacy mode timer 2 is still routed and checked as in R2 and R3.
- R8: A fire whose timer has enable bit 2 clear is ignored. It produces no edge, no legacy activity and no error.
- R9: Fires in the same cycle from several timers merge with OR: timers on the same route give one bit, and timers on different routes give their separate bits.
- R10: `pit_ch0_mute_o` equals, one cycle late, `legacy_mode_i` AND enable bit 2 of timer 0's config.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fire_i | input | NUM_TIMERS (3) | One-cycle fire pulse per timer |
| legacy_mode_i | input | 1 | Legacy replacement mode select |
| tmr_cfg_i | input | NUM_TIMERS x 64 | Per-timer config words: enable bit 2, route 13:9, capability mask 63:32 |
| irq_edge_o | output | NUM_IRQ (24) | One-cycle edge per I/O interrupt input, indexed by route |
| legacy_line_o | output | 2 | Legacy line levels, index 0 is line 0 and index 1 is line 8 |
| legacy_pulse_o | output | 2 | One-cycle pulse marking the reassertion of each legacy line |
| route_err_o | output | NUM_TIMERS (3) | Sticky per-timer invalid-route flag |
| pit_ch0_mute_o | output | 1 | Tells the legacy interval timer to suppress its channel-0 interrupt |

## Verification
The bench builds the block with its default values: three timers and 24 interrupt inputs. With these values every combination of timer, all 32 route codes, and capability bit set or clear can be swept, each from a fresh reset. That covers the routes above the last input as well as the allowed ones. Directed sequences then cover the legacy line drop-and-rise pattern on both indices, timer 2 routing in legacy mode, disabled timers, merged simultaneous fires, error persistence and the mute output.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;

    localparam int CFG_W     = 64;
    localparam int EN_BIT    = 2;
    localparam int ROUTE_LSB = 9;
    localparam int ROUTE_W   = 5;
    localparam int CAP_LSB   = 32;
    localparam int CAP_W     = 32;
    localparam int NUM_LEG   = 2;

    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_DROP = 2'd1
    } leg_state_e;

    typedef struct packed {
        logic                enabled;
        logic [ROUTE_W-1:0]  route;
        logic [CAP_W-1:0]    cap;
    } tmr_fields_t;

    function automatic tmr_fields_t unpack_cfg(input logic [CFG_W-1:0] c);
        tmr_fields_t f;
        f.enabled = c[EN_BIT];
        f.route   = c[ROUTE_LSB +: ROUTE_W];
        f.cap     = c[CAP_LSB +: CAP_W];
        return f;
    endfunction

    function automatic logic route_allowed(input tmr_fields_t f, input int n_irq);
        return (int'(f.route) < n_irq) && f.cap[f.route];
    endfunction

endpackage

// File: rtl/tmr_route_decode.sv
module tmr_route_decode
    import tmr_route_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int NUM_IRQ = 24
) (
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               fire_i,
    input  logic               legacy_i,
    output logic [NUM_IRQ-1:0] edge_o,
    output logic               leg_req_o,
    output logic               err_o
);

    localparam bit HAS_LEGACY = (IDX < NUM_LEG);

    tmr_fields_t f;
    logic        armed;
    logic        use_legacy;
    logic        ok;
    logic        unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_i[CAP_LSB-1:ROUTE_LSB+ROUTE_W],
                               cfg_i[ROUTE_LSB-1:EN_BIT+1], cfg_i[EN_BIT-1:0]};

    always_comb begin
        f          = unpack_cfg(cfg_i);
        armed      = fire_i && f.enabled;
        use_legacy = HAS_LEGACY && legacy_i;
        ok         = route_allowed(f, NUM_IRQ);
        edge_o     = '0;
        if (armed && !use_legacy && ok)
            edge_o = {{(NUM_IRQ-1){1'b0}}, 1'b1} << f.route;
        leg_req_o  = armed && use_legacy;
        err_o      = armed && !use_legacy && !ok;
    end

endmodule

// File: rtl/tmr_legacy_line.sv
module tmr_legacy_line
    import tmr_route_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic line_o,
    output logic pulse_o
);

    leg_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LEG_IDLE;
            line_o  <= 1'b0;
            pulse_o <= 1'b0;
        end else if (req_i) begin
            state_q <= LEG_DROP;
            line_o  <= 1'b0;
            pulse_o <= 1'b0;
        end else if (state_q == LEG_DROP) begin
            state_q <= LEG_IDLE;
            line_o  <= 1'b1;
            pulse_o <= 1'b1;
        end else begin
            pulse_o <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
    import tmr_route_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int NUM_IRQ    = 24
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_TIMERS-1:0]             fire_i,
    input  logic                              legacy_mode_i,
    input  logic [NUM_TIMERS-1:0][CFG_W-1:0]  tmr_cfg_i,
    output logic [NUM_IRQ-1:0]                irq_edge_o,
    output logic [NUM_LEG-1:0]                legacy_line_o,
    output logic [NUM_LEG-1:0]                legacy_pulse_o,
    output logic [NUM_TIMERS-1:0]             route_err_o,
    output logic                              pit_ch0_mute_o
);

    logic [NUM_TIMERS-1:0][NUM_IRQ-1:0] edge_per_tmr;
    logic [NUM_TIMERS-1:0]              leg_req;
    logic [NUM_TIMERS-1:0]              err_now;
    logic [NUM_IRQ-1:0]                 edge_merged;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_dec
        tmr_route_decode #(.IDX(t), .NUM_IRQ(NUM_IRQ)) u_dec (
            .cfg_i     (tmr_cfg_i[t]),
            .fire_i    (fire_i[t]),
            .legacy_i  (legacy_mode_i),
            .edge_o    (edge_per_tmr[t]),
            .leg_req_o (leg_req[t]),
            .err_o     (err_now[t])
        );
    end

    if (NUM_TIMERS > NUM_LEG) begin : g_unused_leg
        logic unused_leg_req;
        assign unused_leg_req = ^leg_req[NUM_TIMERS-1:NUM_LEG];
    end

    always_comb begin
        edge_merged = '0;
        for (int t = 0; t < NUM_TIMERS; t++)
            edge_merged = edge_merged | edge_per_tmr[t];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_edge_o     <= '0;
            route_err_o    <= '0;
            pit_ch0_mute_o <= 1'b0;
        end else begin
            irq_edge_o     <= edge_merged;
            route_err_o    <= route_err_o | err_now;
            pit_ch0_mute_o <= legacy_mode_i && tmr_cfg_i[0][EN_BIT];
        end
    end

    for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg
        tmr_legacy_line u_line (
            .clk     (clk),
            .rst     (rst),
            .req_i   (leg_req[k]),
            .line_o  (legacy_line_o[k]),
            .pulse_o (legacy_pulse_o[k])
        );
    end

endmodule

// File: rtl/tmr_irq_route_chk.sv
module tmr_irq_route_chk
    import tmr_route_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int NUM_IRQ    = 24
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_TIMERS-1:0] fire_i,
    input logic                  legacy_mode_i,
    input logic [NUM_IRQ-1:0]    irq_edge_o,
    input logic [NUM_LEG-1:0]    legacy_line_o,
    input logic [NUM_LEG-1:0]    legacy_pulse_o,
    input logic [NUM_TIMERS-1:0] route_err_o,
    input logic                  pit_ch0_mute_o
);

    AST_EDGE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        (|irq_edge_o) |-> $past(|fire_i)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((route_err_o & $past(route_err_o)) == $past(route_err_o))); // R4

    AST_LEG0_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(route_err_o[0]) |-> !$past(legacy_mode_i)); // R5

    AST_LEG0_PULSE_HIGH: assert property (@(posedge clk) disable iff (rst)
        legacy_pulse_o[0] |-> legacy_line_o[0]); // R6

    AST_LEG1_PULSE_HIGH: assert property (@(posedge clk) disable iff (rst)
        legacy_pulse_o[1] |-> legacy_line_o[1]); // R6

    AST_LEG0_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        legacy_pulse_o[0] |-> $past(!legacy_line_o[0])); // R6

    AST_LEG1_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        legacy_pulse_o[1] |-> $past(!legacy_line_o[1])); // R6

    AST_MUTE_NEEDS_LEGACY: assert property (@(posedge clk) disable iff (rst)
        pit_ch0_mute_o |-> $past(legacy_mode_i)); // R10

endmodule

bind tmr_irq_route tmr_irq_route_chk #(.NUM_TIMERS(NUM_TIMERS), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fire_i         (fire_i),
    .legacy_mode_i  (legacy_mode_i),
    .irq_edge_o     (irq_edge_o),
    .legacy_line_o  (legacy_line_o),
    .legacy_pulse_o (legacy_pulse_o),
    .route_err_o    (route_err_o),
    .pit_ch0_mute_o (pit_ch0_mute_o)
);

// File: tb/sim_tmr_irq_route.sv
`timescale 1ns/1ps
module sim_tmr_irq_route;

    localparam int NT = 3;
    localparam int NI = 24;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NT-1:0]        fire_i = '0;
    logic                 legacy_mode_i = 1'b0;
    logic [NT-1:0][63:0]  tmr_cfg_i = '0;
    logic [NI-1:0]        irq_edge_o;
    logic [1:0]           legacy_line_o;
    logic [1:0]           legacy_pulse_o;
    logic [NT-1:0]        route_err_o;
    logic                 pit_ch0_mute_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_irq_route #(.NUM_TIMERS(NT), .NUM_IRQ(NI)) u0 (
        .clk(clk), .rst(rst), .fire_i(fire_i), .legacy_mode_i(legacy_mode_i),
        .tmr_cfg_i(tmr_cfg_i), .irq_edge_o(irq_edge_o), .legacy_line_o(legacy_line_o),
        .legacy_pulse_o(legacy_pulse_o), .route_err_o(route_err_o),
        .pit_ch0_mute_o(pit_ch0_mute_o)
    );

    function automatic logic [63:0] mk_cfg(input logic en, input logic [4:0] route,
                                           input logic [31:0] cap);
        return {cap, 18'd0, route, 6'd0, en, 2'd0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fire_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive fire at a negedge; return at the next negedge (outputs of the sampling edge visible)
    task automatic fire(input logic [NT-1:0] m);
        @(negedge clk);
        fire_i = m;
        @(negedge clk);
        fire_i = '0;
    endtask

    initial begin
        logic [NI-1:0] exp_vec;
        logic          ok;
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 irq", 64'(irq_edge_o), 0);
        chk("R1 legacy line", 64'(legacy_line_o), 0);
        chk("R1 legacy pulse", 64'(legacy_pulse_o), 0);
        chk("R1 err", 64'(route_err_o), 0);
        chk("R1 mute", 64'(pit_ch0_mute_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", 64'({irq_edge_o, legacy_line_o, legacy_pulse_o,
                                     route_err_o, pit_ch0_mute_o}), 0);

        // R2/R3: exhaustive timer x route x capability sweep
        for (int n = 0; n < NT; n++) begin
            for (int r = 0; r < 32; r++) begin
                for (int c = 0; c < 2; c++) begin
                    do_reset();
                    legacy_mode_i = 1'b0;
                    tmr_cfg_i = '0;
                    tmr_cfg_i[n] = mk_cfg(1'b1, 5'(r),
                                          (c == 1) ? (32'd1 << r) : ~(32'd1 << r));
                    ok = (c == 1) && (r < NI);
                    exp_vec = ok ? (NI'(1) << r) : '0;
                    fire(NT'(1) << n);
                    chk(ok ? "R2 routed edge" : "R3 no edge on bad route",
                        64'(irq_edge_o), 64'(exp_vec));
                    chk("R3 error flag", 64'(route_err_o), ok ? 0 : 64'(NT'(1) << n));
                    @(negedge clk);
                    chk("R2 single cycle", 64'(irq_edge_o), 0);
                end
            end
        end

        // R4: sticky error
        do_reset();
        tmr_cfg_i = '0;
        tmr_cfg_i[1] = mk_cfg(1'b1, 5'd3, 32'h00F0_0000);
        fire(3'b010);
        tmr_cfg_i[1] = mk_cfg(1'b1, 5'd21, 32'h00F0_0000);
        repeat (5) @(negedge clk);
        fire(3'b010);
        chk("R4 good fire delivered", 64'(irq_edge_o), 64'(NI'(1) << 21));
        chk("R4 error kept", 64'(route_err_o), 64'h2);
        do_reset();
        chk("R4 cleared by reset", 64'(route_err_o), 0);

        // R5/R6: legacy mode, timers 0 and 1 with valid and invalid route fields
        do_reset();
        legacy_mode_i = 1'b1;
        tmr_cfg_i[0] = mk_cfg(1'b1, 5'd20, 32'h00F0_0000);
        tmr_cfg_i[1] = mk_cfg(1'b1, 5'd2, 32'h0);
        tmr_cfg_i[2] = mk_cfg(1'b0, 5'd0, 32'h0);
        fire(3'b001);
        chk("R5 no routed edge for t0", 64'(irq_edge_o), 0);
        chk("R6 line0 low after fire", 64'(legacy_line_o), 0);
        @(negedge clk);
        chk("R6 line0 raised", 64'(legacy_line_o), 64'h1);
        chk("R6 pulse0", 64'(legacy_pulse_o), 64'h1);
        @(negedge clk);
        chk("R6 pulse0 one cycle", 64'(legacy_pulse_o), 0);
        chk("R6 line0 held", 64'(legacy_line_o), 64'h1);
        fire(3'b010);
        chk("R5 no error for t1 bad route", 64'(route_err_o), 0);
        chk("R5 no routed edge for t1", 64'(irq_edge_o), 0);
        chk("R6 line8 low, line0 high", 64'(legacy_line_o), 64'h1);
        @(negedge clk);
        chk("R6 line8 raised", 64'(legacy_line_o), 64'h3);
        chk("R6 pulse8", 64'(legacy_pulse_o), 64'h2);
        fire(3'b001);
        chk("R6 line0 drops again", 64'(legacy_line_o), 64'h2);
        @(negedge clk);
        chk("R6 line0 reasserted", 64'(legacy_line_o), 64'h3);

        // R7: timer 2 routed in legacy mode
        tmr_cfg_i[2] = mk_cfg(1'b1, 5'd22, 32'h00F0_0000);
        fire(3'b100);
        chk("R7 t2 routed in legacy", 64'(irq_edge_o), 64'(NI'(1) << 22));
        tmr_cfg_i[2] = mk_cfg(1'b1, 5'd5, 32'h00F0_0000);
        fire(3'b100);
        chk("R7 t2 error in legacy", 64'(route_err_o), 64'h4);

        // R8: disabled timers ignored
        do_reset();
        legacy_mode_i = 1'b0;
        tmr_cfg_i[0] = mk_cfg(1'b0, 5'd20, 32'h00F0_0000);
        tmr_cfg_i[1] = mk_cfg(1'b0, 5'd4, 32'h0);
        tmr_cfg_i[2] = mk_cfg(1'b0, 5'd23, 32'h00F0_0000);
        fire(3'b111);
        chk("R8 no edge when disabled", 64'(irq_edge_o), 0);
        chk("R8 no error when disabled", 64'(route_err_o), 0);
        legacy_mode_i = 1'b1;
        fire(3'b011);
        @(negedge clk);
        chk("R8 no legacy activity when disabled",
            64'({legacy_line_o, legacy_pulse_o}), 0);

        // R9: merged simultaneous fires
        legacy_mode_i = 1'b0;
        for (int t = 0; t < NT; t++) tmr_cfg_i[t] = mk_cfg(1'b1, 5'd20, 32'h00F0_0000);
        fire(3'b111);
        chk("R9 same route merged", 64'(irq_edge_o), 64'(NI'(1) << 20));
        for (int t = 0; t < NT; t++)
            tmr_cfg_i[t] = mk_cfg(1'b1, 5'(21 + t), 32'h00F0_0000);
        fire(3'b111);
        chk("R9 distinct routes", 64'(irq_edge_o), 64'(NI'(7) << 21));

        // R10: mute output
        do_reset();
        legacy_mode_i = 1'b1;
        tmr_cfg_i[0] = mk_cfg(1'b1, 5'd20, 32'h0);
        @(negedge clk);
        chk("R10 mute on", 64'(pit_ch0_mute_o), 1);
        tmr_cfg_i[0] = mk_cfg(1'b0, 5'd20, 32'h0);
        @(negedge clk);
        chk("R10 mute off when t0 disabled", 64'(pit_ch0_mute_o), 0);
        tmr_cfg_i[0] = mk_cfg(1'b1, 5'd20, 32'h0);
        legacy_mode_i = 1'b0;
        @(negedge clk);
        chk("R10 mute off outside legacy", 64'(pit_ch0_mute_o), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule